// File: doc/BRIEF.md
# CHR Window and Nametable Mirroring Mapper

This block is the picture-memory side of a cartridge bank controller. It splits the 8 KiB pattern space seen by the picture processor into eight 1 KiB windows, each pointing at its own bank of a CHR memory, and turns each picture-processor fetch into a wide CHR memory address. It also drives the A10 line of the console's nametable RAM from a two-bit mirroring mode.

The CPU programs the block through a decoded register write: a 4-bit group number (the top nibble of the CPU address), a 2-bit sub-index and a data byte. Each 9-bit bank number is loaded as two separate halves, a 4-bit low part and a 5-bit high part. A legacy parameter narrows the bank numbers to 8 bits and the mirroring choice to two modes. A second parameter models boards that discard the lowest bank bit.

Top module: `chr_mirror_mapper`

## Requirements
- R1: After reset every window's bank number is 0 and the mirroring mode is 0 (vertical).
- R2: For a pattern fetch, ppuAddr[12:10] picks the window and chrAddr equals {effective bank number, ppuAddr[9:0]}, 19 bits.
- R3: A write to group 4'hB, 4'hC, 4'hD or 4'hE targets window 2*(group-4'hB)+wrSub[1]; wrSub[0]=0 loads bank bits 3:0 from wrData[3:0], wrSub[0]=1 loads bank bits 8:4 from wrData[4:0].
- R4: Writing one half of a bank number leaves the other half of that bank and all other banks unchanged.
- R5: With LEGACY=1, wrData[4] of a high-half write is ignored, so bank numbers never exceed 255.
- R6: With DROP_LOW_BIT=1, the effective bank number is the assembled 9-bit number shifted right by one place.
- R7: A write to group 4'h9, sub-index 0 loads the mirroring mode from wrData[1:0]; with LEGACY=0, group 4'h9 at sub-index 1 to 3 and writes to groups 4'h0 to 4'h8, 4'hA and 4'hF change nothing.
- R8: ntA10 is ppuAddr[10] in mode 0, ppuAddr[11] in mode 1, 0 in mode 2 and 1 in mode 3.
- R9: With LEGACY=1, wrData[1] of a mirroring write is ignored (mode 0 or 1 only) and the mirroring register responds at every sub-index of group 4'h9.
- R10: While wrEn is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrGroup | input | 4 | Decoded register group (CPU address bits 15:12) |
| wrSub | input | 2 | Register sub-index inside the group |
| wrData | input | 8 | Write data byte |
| ppuAddr | input | 14 | Picture-processor address |
| chrAddr | output | 19 | CHR memory address |
| ntA10 | output | 1 | Nametable RAM A10 line |

## Verification
The hardest situation to reach from the ports is a bank number whose two halves hold unrelated values that were written at different times, since only then does a half-write leaking into its partner show up. The bench first loads every window with distinct low and high values derived from the window index, then rewrites single halves and sweeps all eight windows at several offsets, comparing against an arithmetic model for both a full instance and a legacy instance with the low bit dropped. Mirroring sub-index writes at 1 to 3 are sent to both instances at once so that the same stimulus must be ignored by one and accepted by the other.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
  localparam int WIN_COUNT = 8;
  localparam int LO_W      = 4;
  localparam int HI_W      = 5;
  localparam int BANK_W    = LO_W + HI_W;
  localparam int WIN_SEL_W = $clog2(WIN_COUNT);

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_SINGLE0 = 2'd2,
    MIR_SINGLE1 = 2'd3
  } mirMode_e;

  typedef struct packed {
    logic [WIN_COUNT-1:0] loWr;
    logic [WIN_COUNT-1:0] hiWr;
    logic                 mirWr;
  } chrStrobe_t;
endpackage

// File: rtl/chr_write_decode.sv
module chr_write_decode
  import chr_map_pkg::*;
#(
  parameter bit LEGACY = 1'b0,
  parameter int GROUP_W = 4,
  parameter int SUB_W = 2,
  parameter logic [GROUP_W-1:0] MIR_GROUP = 4'h9,
  parameter logic [GROUP_W-1:0] BANK_FIRST = 4'hB,
  parameter logic [GROUP_W-1:0] BANK_LAST = 4'hE
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [GROUP_W-1:0] wrGroup,
  input  logic [SUB_W-1:0]   wrSub,
  output chrStrobe_t         strb
);
  logic [GROUP_W-1:0]   grpOff;
  logic                 inBankRange;
  logic [WIN_SEL_W-1:0] winIdx;
  logic                 mirHit;

  assign grpOff      = wrGroup - BANK_FIRST;
  assign inBankRange = (wrGroup >= BANK_FIRST) && (wrGroup <= BANK_LAST);
  assign winIdx      = {grpOff[WIN_SEL_W-2:0], wrSub[1]};

  generate
    if (LEGACY) begin : g_mirAny
      assign mirHit = (wrGroup == MIR_GROUP);
    end else begin : g_mirSub0
      assign mirHit = (wrGroup == MIR_GROUP) && (wrSub == '0);
    end
  endgenerate

  always_comb begin
    strb = '0;
    if (wrEn) begin
      if (inBankRange) begin
        if (wrSub[0]) strb.hiWr[winIdx] = 1'b1;
        else          strb.loWr[winIdx] = 1'b1;
      end
      strb.mirWr = mirHit;
    end
  end

  // R3: at most one register is targeted per write
  a_r3_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loWr, strb.hiWr, strb.mirWr}));

  // R10: no strobe while the write enable is low
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (strb == '0));

  // R7: bank groups never touch mirroring
  a_r7_bank_not_mirror: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && inBankRange) |-> !strb.mirWr);
endmodule

// File: rtl/chr_bank_datapath.sv
module chr_bank_datapath
  import chr_map_pkg::*;
#(
  parameter bit LEGACY = 1'b0,
  parameter bit DROP_LOW_BIT = 1'b0,
  parameter int DATA_W = 8,
  parameter int PPU_W = 14,
  parameter int OFS_W = 10,
  localparam int CHR_W = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  chrStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PPU_W-1:0]  ppuAddr,
  output logic [CHR_W-1:0]  chrAddr,
  output logic              ntA10
);
  logic [LO_W-1:0] loReg [WIN_COUNT];
  logic [HI_W-1:0] hiReg [WIN_COUNT];
  logic [HI_W-1:0] hiIn;
  logic [1:0]      mirReg;
  logic [1:0]      mirIn;

  generate
    if (LEGACY) begin : g_legacyIn
      assign hiIn  = {1'b0, wrData[HI_W-2:0]};
      assign mirIn = {1'b0, wrData[0]};
    end else begin : g_fullIn
      assign hiIn  = wrData[HI_W-1:0];
      assign mirIn = wrData[1:0];
    end
  endgenerate

  generate
    for (genvar i = 0; i < WIN_COUNT; i++) begin : g_win
      always_ff @(posedge clk) begin
        if (!rstN) begin
          loReg[i] <= '0;
          hiReg[i] <= '0;
        end else begin
          if (strb.loWr[i]) loReg[i] <= wrData[LO_W-1:0];
          if (strb.hiWr[i]) hiReg[i] <= hiIn;
        end
      end

      // R4: a low-half write keeps the high half
      a_r4_low_keeps_high: assert property (@(posedge clk) disable iff (!rstN)
        strb.loWr[i] |=> $stable(hiReg[i]));
      // R4: a high-half write keeps the low half
      a_r4_high_keeps_low: assert property (@(posedge clk) disable iff (!rstN)
        strb.hiWr[i] |=> $stable(loReg[i]));
      // R5: legacy banks stay below 256
      a_r5_legacy_cap: assert property (@(posedge clk) disable iff (!rstN)
        LEGACY |-> (hiReg[i][HI_W-1] == 1'b0));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)          mirReg <= MIR_VERT;
    else if (strb.mirWr) mirReg <= mirIn;
  end

  // R9: legacy mode never holds a single-screen mode
  a_r9_legacy_two_modes: assert property (@(posedge clk) disable iff (!rstN)
    LEGACY |-> (mirReg[1] == 1'b0));

  logic [WIN_SEL_W-1:0] winSel;
  logic [BANK_W-1:0]    rawBank;
  logic [BANK_W-1:0]    effBank;

  assign winSel  = ppuAddr[OFS_W+WIN_SEL_W-1:OFS_W];
  assign rawBank = {hiReg[winSel], loReg[winSel]};

  generate
    if (DROP_LOW_BIT) begin : g_drop
      assign effBank = {1'b0, rawBank[BANK_W-1:1]};
    end else begin : g_keep
      assign effBank = rawBank;
    end
  endgenerate

  assign chrAddr = {effBank, ppuAddr[OFS_W-1:0]};

  always_comb begin
    unique case (mirMode_e'(mirReg))
      MIR_VERT:    ntA10 = ppuAddr[10];
      MIR_HORZ:    ntA10 = ppuAddr[11];
      MIR_SINGLE0: ntA10 = 1'b0;
      MIR_SINGLE1: ntA10 = 1'b1;
      default:     ntA10 = 1'b0;
    endcase
  end
endmodule

// File: rtl/chr_mirror_mapper.sv
module chr_mirror_mapper
  import chr_map_pkg::*;
#(
  parameter bit LEGACY = 1'b0,
  parameter bit DROP_LOW_BIT = 1'b0,
  parameter int DATA_W = 8,
  parameter int PPU_W = 14,
  parameter int OFS_W = 10,
  localparam int CHR_W = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrGroup,
  input  logic [1:0]        wrSub,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PPU_W-1:0]  ppuAddr,
  output logic [CHR_W-1:0]  chrAddr,
  output logic              ntA10
);
  chrStrobe_t strb;

  chr_write_decode #(.LEGACY(LEGACY)) u_decode (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .wrGroup(wrGroup), .wrSub(wrSub), .strb(strb)
  );

  chr_bank_datapath #(
    .LEGACY(LEGACY), .DROP_LOW_BIT(DROP_LOW_BIT),
    .DATA_W(DATA_W), .PPU_W(PPU_W), .OFS_W(OFS_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .ppuAddr(ppuAddr), .chrAddr(chrAddr), .ntA10(ntA10)
  );

  // R2: window offset passes straight through
  a_r2_offset_through: assert property (@(posedge clk) disable iff (!rstN)
    chrAddr[OFS_W-1:0] == ppuAddr[OFS_W-1:0]);

  // R6: dropping the low bit clears the top address bit
  a_r6_drop_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    DROP_LOW_BIT |-> (chrAddr[CHR_W-1] == 1'b0));

  // R1: vertical mirroring right after reset
  a_r1_reset_vertical: assert property (@(posedge clk)
    !rstN |=> (ntA10 == ppuAddr[10]));
endmodule

// File: tb/tb_chr_mirror_mapper.sv
module tb_chr_mirror_mapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrGroup = '0;
  logic [1:0]  wrSub = '0;
  logic [7:0]  wrData = '0;
  logic [13:0] ppuAddr = '0;
  logic [18:0] chrAddr, chrAddrL;
  logic        ntA10, ntA10L;

  int checks = 0;
  int fails = 0;

  logic [3:0] mLo [8];
  logic [4:0] mHi [8];
  logic [3:0] lLo [8];
  logic [4:0] lHi [8];
  logic [1:0] mMir, lMir;

  always #5 clk = ~clk;

  chr_mirror_mapper dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrGroup(wrGroup), .wrSub(wrSub),
    .wrData(wrData), .ppuAddr(ppuAddr), .chrAddr(chrAddr), .ntA10(ntA10)
  );

  chr_mirror_mapper #(.LEGACY(1'b1), .DROP_LOW_BIT(1'b1)) dutLeg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrGroup(wrGroup), .wrSub(wrSub),
    .wrData(wrData), .ppuAddr(ppuAddr), .chrAddr(chrAddrL), .ntA10(ntA10L)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h ppuAddr=%0h", req, act, exp, ppuAddr);
    end
  endtask

  task automatic modelWrite(logic [3:0] g, logic [1:0] s, logic [7:0] d);
    if (g >= 4'hB && g <= 4'hE) begin
      int w = (int'(g) - 11) * 2 + int'(s[1]);
      if (!s[0]) begin
        mLo[w] = d[3:0];
        lLo[w] = d[3:0];
      end else begin
        mHi[w] = d[4:0];
        lHi[w] = {1'b0, d[3:0]};
      end
    end
    if (g == 4'h9) begin
      if (s == 2'd0) mMir = d[1:0];
      lMir = {1'b0, d[0]};
    end
  endtask

  task automatic doWrite(logic [3:0] g, logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrGroup = g; wrSub = s; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(g, s, d);
  endtask

  task automatic idleWrite(logic [3:0] g, logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b0; wrGroup = g; wrSub = s; wrData = d;
    @(negedge clk);
  endtask

  task automatic writeBank(int w, logic [8:0] b);
    logic [3:0] g = 4'(11 + w / 2);
    doWrite(g, {1'(w % 2), 1'b0}, {4'hF, b[3:0]});
    doWrite(g, {1'(w % 2), 1'b1}, {3'b111, b[8:4]});
  endtask

  task automatic checkBanks(string req);
    for (int w = 0; w < 8; w++) begin
      for (int k = 0; k < 3; k++) begin
        logic [9:0] ofs = (k == 0) ? 10'h000 : (k == 1) ? 10'h2A5 : 10'h3FF;
        logic [8:0] full = {mHi[w], mLo[w]};
        logic [8:0] leg = {lHi[w], lLo[w]} >> 1;
        ppuAddr = {1'b0, 3'(w), ofs};
        #1;
        check(req, 32'(chrAddr), 32'({full, ofs}));
        check({req, "/R6"}, 32'(chrAddrL), 32'({leg, ofs}));
      end
    end
  endtask

  function automatic logic expNt(logic [1:0] m, logic [13:0] a);
    case (m)
      2'd0: return a[10];
      2'd1: return a[11];
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic checkMirror(string req);
    for (int q = 0; q < 4; q++) begin
      ppuAddr = {2'b10, 2'(q), 10'h155};
      #1;
      check(req, 32'(ntA10), 32'(expNt(mMir, ppuAddr)));
      check({req, "/R9"}, 32'(ntA10L), 32'(expNt(lMir, ppuAddr)));
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      mLo[i] = '0; mHi[i] = '0; lLo[i] = '0; lHi[i] = '0;
    end
    mMir = 2'd0; lMir = 2'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checkBanks("R1");
    checkMirror("R1");

    // R3/R2: distinct value in every window
    for (int w = 0; w < 8; w++) writeBank(w, 9'((w * 67 + 21) % 512));
    checkBanks("R3");

    // R5: high halves with bit 4 set
    for (int w = 0; w < 8; w++) writeBank(w, 9'(9'h100 | 9'((w * 29 + 5) % 256)));
    checkBanks("R5");

    // R4: single-half rewrites
    doWrite(4'hC, 2'd2, 8'h0A);
    checkBanks("R4");
    doWrite(4'hE, 2'd1, 8'h13);
    checkBanks("R4");
    doWrite(4'hB, 2'd0, 8'hF6);
    checkBanks("R4");

    // R10: idle bus carries write-like data
    idleWrite(4'hB, 2'd1, 8'hFF);
    idleWrite(4'hD, 2'd0, 8'h00);
    idleWrite(4'h9, 2'd0, 8'h03);
    checkBanks("R10");
    checkMirror("R10");

    // R7: writes to unrelated groups
    for (int g = 0; g < 16; g++) begin
      if (g == 9 || (g >= 11 && g <= 14)) continue;
      for (int s = 0; s < 4; s++) doWrite(4'(g), 2'(s), 8'hFF);
    end
    checkBanks("R7");
    checkMirror("R7");

    // R8: every mirroring mode
    for (int m = 0; m < 4; m++) begin
      doWrite(4'h9, 2'd0, 8'(8'hFC | m));
      checkMirror("R8");
    end

    // R9/R7: sub-index 1..3 of group 9
    doWrite(4'h9, 2'd0, 8'h00);
    for (int s = 1; s < 4; s++) begin
      doWrite(4'h9, 2'(s), 8'(s));
      checkMirror("R9");
    end

    // R6/R2: extreme bank numbers
    for (int w = 0; w < 8; w++) writeBank(w, (w % 2 == 0) ? 9'h1FF : 9'h001);
    checkBanks("R6");

    // R1: reset clears everything again
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < 8; i++) begin
      mLo[i] = '0; mHi[i] = '0; lLo[i] = '0; lHi[i] = '0;
    end
    mMir = 2'd0; lMir = 2'd0;
    checkBanks("R1");
    checkMirror("R1");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule